// File: doc/BRIEF.md
# Adaptive Dual-Rate Sampling Controller

This block paces the sampling of a low-power magnetic switch that runs from its own time base. It alternates between a short awake window, during which the sensing path is powered and a field sample is taken, and a sleep interval, during which the last decision is held. The sleep interval adapts to activity. It starts long. After any change of the latched decision it shortens to a fixed multiple of the awake window, so that fast rotation is not missed. After a long stretch with no change it lengthens again, which saves power.

Time is counted in ticks from a slow reference strobe. The window length, the slow period, the fast multiplier and the timeout are all parameters in ticks, so they can be shortened for test. A mode decoder upstream drives the enable. Dropping the enable parks the block: it sleeps with cleared timers and holds its decision, and the next entry starts at the slow rate.

The decision follows a hysteresis rule. A sample at or above the operate threshold asserts it. A sample at or below the release threshold clears it. A sample between the two leaves it unchanged.

Top module: `dual_rate_sampler`

## Requirements
- R1: After reset `awake_o`, `det_o` and `fast_o` are all 0.
- R2: When the enable rises from the disabled state, the block first sleeps for SLOW_PERIOD_TICKS-AWAKE_TICKS ticks and then opens its first awake window, with `fast_o` at 0.
- R3: `awake_o` stays high for exactly AWAKE_TICKS ticks in every window, at both rates.
- R4: The field is sampled on the final tick of each awake window. A value >= OP_THR sets `det_o` to 1. A value <= RP_THR clears it to 0. A value strictly between the two leaves it unchanged. `det_o` changes at no other time.
- R5: A sample that changes `det_o` sets `fast_o` to 1 on the same clock edge. While `fast_o` is 1, each sleep lasts FAST_SLEEP_MULT*AWAKE_TICKS ticks.
- R6: While `fast_o` is 0, each sleep lasts SLOW_PERIOD_TICKS-AWAKE_TICKS ticks.
- R7: Every change of `det_o` restarts the return timer. `fast_o` falls exactly TIMEOUT_PERIODS*SLOW_PERIOD_TICKS ticks after the most recent change, provided no further change occurs.
- R8: If the timeout expires during a sleep, the sleep restarts at the slow length. The next window then opens SLOW_PERIOD_TICKS-AWAKE_TICKS ticks after `fast_o` falls.
- R9: With `en_i` low, `awake_o` and `fast_o` are 0 from the next cycle on and no sample is taken. This holds even if the enable drops mid-window. `det_o` keeps its value.
- R10: In a cycle with `tick_i` low, neither the sleep/awake count nor the return timer advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base strobe; one tick per high cycle |
| en_i | input | 1 | Mode enable from the decoder |
| field_i | input | FIELD_W | Signed field sample (two's complement) |
| awake_o | output | 1 | Sensing path powered (awake window) |
| det_o | output | 1 | Latched hysteresis decision |
| fast_o | output | 1 | 1 = fast sampling rate, 0 = slow |

## Verification
The bench hits the thresholds exactly, at the boundary values, and one count inside them. A design that used strict comparisons, or that let an in-band sample clear the decision, would report a wrong `det_o`. It makes changes late in the fast phase and then times the fall of `fast_o` from the last one. A return timer that is not reloaded would fall too early. A timeout that does not restart the sleep would open the next window after a leftover fast-length sleep. The bench also stalls the tick mid-sleep and drops the enable inside a window while driving a field that would clear the decision. A design that counts without ticks, or that samples while disabled, would show a shortened sleep, a lingering `awake_o` or a lost `det_o`.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic {
    PH_SLEEP = 1'b0,
    PH_AWAKE = 1'b1
  } phase_e;

  function automatic int unsigned cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/drs_phase_timer.sv
module drs_phase_timer
  import drs_pkg::*;
#(
  parameter int unsigned AWAKE_TICKS = 5,
  parameter int unsigned SLOW_SLEEP  = 5595,
  parameter int unsigned FAST_SLEEP  = 40,
  parameter int unsigned CW          = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic fast_i,
  input  logic reload_i,
  output logic awake_o,
  output logic sample_o
);

  localparam logic [CW-1:0] AW_LAST = CW'(AWAKE_TICKS - 1);
  localparam logic [CW-1:0] SS_LAST = CW'(SLOW_SLEEP - 1);
  localparam logic [CW-1:0] FS_LAST = CW'(FAST_SLEEP - 1);

  phase_e          ph_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   sleep_last;

  assign sleep_last = fast_i ? FS_LAST : SS_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_SLEEP;
      cnt_q <= '0;
    end else if (!en_i) begin
      ph_q  <= PH_SLEEP;
      cnt_q <= '0;
    end else if (reload_i && ph_q == PH_SLEEP) begin
      cnt_q <= '0;  // timeout: restart sleep at slow length
    end else if (tick_i) begin
      if (ph_q == PH_AWAKE) begin
        if (cnt_q == AW_LAST) begin
          ph_q  <= PH_SLEEP;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        if (cnt_q == sleep_last) begin
          ph_q  <= PH_AWAKE;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign awake_o  = (ph_q == PH_AWAKE);
  assign sample_o = en_i && tick_i && (ph_q == PH_AWAKE) && (cnt_q == AW_LAST);

  a_r10_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i && !reload_i |=> $stable(cnt_q) && $stable(ph_q));

  a_r3_awake_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_AWAKE |-> cnt_q <= AW_LAST);

  a_r6_sleep_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_SLEEP |-> cnt_q <= sleep_last);

  a_r9_idle_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ph_q == PH_SLEEP && cnt_q == '0);

endmodule

// File: rtl/drs_hyst_latch.sv
module drs_hyst_latch #(
  parameter int FIELD_W = 12,
  parameter int OP_THR  = 36,
  parameter int RP_THR  = -36
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sample_i,
  input  logic signed [FIELD_W-1:0] field_i,
  output logic                      det_o,
  output logic                      chg_o
);

  localparam logic signed [FIELD_W-1:0] OP_V = FIELD_W'(OP_THR);
  localparam logic signed [FIELD_W-1:0] RP_V = FIELD_W'(RP_THR);

  logic det_q;
  logic det_nxt;

  always_comb begin
    det_nxt = det_q;
    if (field_i >= OP_V)      det_nxt = 1'b1;
    else if (field_i <= RP_V) det_nxt = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       det_q <= 1'b0;
    else if (sample_i) det_q <= det_nxt;
  end

  assign det_o = det_q;
  assign chg_o = sample_i && (det_nxt != det_q);

  a_r4_set_at_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && field_i >= OP_V |=> det_o);

  a_r4_clear_at_rp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && field_i <= RP_V |=> !det_o);

  a_r4_hold_off_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(det_o));

endmodule

// File: rtl/drs_return_timer.sv
module drs_return_timer #(
  parameter int unsigned TIMEOUT_TICKS = 560000,
  parameter int unsigned RW            = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic chg_i,
  output logic fast_o,
  output logic expire_o
);

  localparam logic [RW-1:0] RT_LAST = RW'(TIMEOUT_TICKS - 1);

  logic          fast_q;
  logic [RW-1:0] ret_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q <= 1'b0;
      ret_q  <= '0;
    end else if (!en_i) begin
      fast_q <= 1'b0;
      ret_q  <= '0;
    end else if (chg_i) begin
      fast_q <= 1'b1;
      ret_q  <= '0;
    end else if (fast_q && tick_i) begin
      if (ret_q == RT_LAST) begin
        fast_q <= 1'b0;
        ret_q  <= '0;
      end else begin
        ret_q <= ret_q + RW'(1);
      end
    end
  end

  assign fast_o   = fast_q;
  assign expire_o = en_i && fast_q && tick_i && !chg_i && (ret_q == RT_LAST);

  a_r5_enter_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && chg_i |=> fast_o && ret_q == '0);

  a_r7_ret_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_q |-> ret_q <= RT_LAST);

  a_r10_ret_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i && !chg_i |=> $stable(ret_q) && $stable(fast_q));

  a_r9_slow_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fast_o && ret_q == '0);

endmodule

// File: rtl/dual_rate_sampler.sv
module dual_rate_sampler
  import drs_pkg::*;
#(
  parameter int          FIELD_W           = 12,
  parameter int          OP_THR            = 36,
  parameter int          RP_THR            = -36,
  parameter int unsigned AWAKE_TICKS       = 5,
  parameter int unsigned SLOW_PERIOD_TICKS = 5600,
  parameter int unsigned FAST_SLEEP_MULT   = 8,
  parameter int unsigned TIMEOUT_PERIODS   = 100
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      en_i,
  input  logic signed [FIELD_W-1:0] field_i,
  output logic                      awake_o,
  output logic                      det_o,
  output logic                      fast_o
);

  localparam int unsigned SLOW_SLEEP    = SLOW_PERIOD_TICKS - AWAKE_TICKS;
  localparam int unsigned FAST_SLEEP    = FAST_SLEEP_MULT * AWAKE_TICKS;
  localparam int unsigned TIMEOUT_TICKS = TIMEOUT_PERIODS * SLOW_PERIOD_TICKS;
  localparam int unsigned PH_W          = cnt_w(max3(AWAKE_TICKS, SLOW_SLEEP, FAST_SLEEP));
  localparam int unsigned RT_W          = cnt_w(TIMEOUT_TICKS);

  logic sample;
  logic chg;
  logic expire;

  drs_phase_timer #(
    .AWAKE_TICKS (AWAKE_TICKS),
    .SLOW_SLEEP  (SLOW_SLEEP),
    .FAST_SLEEP  (FAST_SLEEP),
    .CW          (PH_W)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick_i),
    .fast_i   (fast_o),
    .reload_i (expire),
    .awake_o  (awake_o),
    .sample_o (sample)
  );

  drs_hyst_latch #(
    .FIELD_W (FIELD_W),
    .OP_THR  (OP_THR),
    .RP_THR  (RP_THR)
  ) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .field_i  (field_i),
    .det_o    (det_o),
    .chg_o    (chg)
  );

  drs_return_timer #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .RW            (RT_W)
  ) u_ret (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick_i),
    .chg_i    (chg),
    .fast_o   (fast_o),
    .expire_o (expire)
  );

  a_r5_fast_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fast_o) |-> !$stable(det_o));

  a_r4_change_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(det_o) |-> $past(awake_o));

  a_r9_no_window_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !awake_o);

endmodule

// File: tb/dual_rate_sampler_tb.sv
`timescale 1ns/1ps
module dual_rate_sampler_tb;

  localparam int AW   = 4;
  localparam int SP   = 100;
  localparam int MULT = 8;
  localparam int TP   = 3;
  localparam int SS   = SP - AW;     // 96
  localparam int FS   = MULT * AW;   // 32
  localparam int TO   = TP * SP;     // 300

  // per-window vectors: field, expected det, expected fast, expected preceding sleep
  localparam int NV = 7;
  localparam int V_FIELD [NV] = '{0, 35, 36, 100, -35, -36, 36};
  localparam int V_DET   [NV] = '{0, 0, 1, 1, 1, 0, 1};
  localparam int V_FAST  [NV] = '{0, 0, 1, 1, 1, 1, 1};
  localparam int V_SLEEP [NV] = '{SS, SS, SS, FS, FS, FS, FS};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic en = 1'b0;
  logic signed [11:0] field = '0;
  logic awake, det, fast;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_rate_sampler #(
    .FIELD_W           (12),
    .OP_THR            (36),
    .RP_THR            (-36),
    .AWAKE_TICKS       (AW),
    .SLOW_PERIOD_TICKS (SP),
    .FAST_SLEEP_MULT   (MULT),
    .TIMEOUT_PERIODS   (TP)
  ) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .en_i    (en),
    .field_i (field),
    .awake_o (awake),
    .det_o   (det),
    .fast_o  (fast)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count negedges with awake low, starting at the current one
  task automatic count_sleep(output int n);
    n = 0;
    while (!awake) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_awake(output int n);
    n = 0;
    while (awake) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    int bad;
    repeat (3) @(negedge clk);
    chk("R1 awake after reset", awake, 0);
    chk("R1 det after reset", det, 0);
    chk("R1 fast after reset", fast, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: entry starts with a slow sleep
    en = 1'b1;
    count_sleep(n);
    chk("R2 first sleep length", n, SS);
    chk("R2 slow at entry", fast, 0);
    count_awake(n);
    chk("R3 window length slow", n, AW);

    // R4 R5 R6: vector table, one entry per window
    for (int i = 0; i < NV; i++) begin
      count_sleep(n);
      chk(V_SLEEP[i] == SS ? "R6 slow sleep length" : "R5 fast sleep length", n, V_SLEEP[i]);
      field = 12'(V_FIELD[i]);
      count_awake(n);
      chk("R3 window length", n, AW);
      chk("R4 det after window", det, V_DET[i]);
      chk("R5 fast after window", fast, V_FAST[i]);
    end

    // R7: timeout measured from the last change
    field = '0;
    n = 0;
    while (fast) begin
      n++;
      @(negedge clk);
    end
    chk("R7 fast duration after last change", n, TO);
    chk("R7 det held through timeout", det, 1);
    chk("R8 asleep at timeout", awake, 0);
    count_sleep(n);
    chk("R8 sleep restarted at slow length", n, SS);
    count_awake(n);
    chk("R3 window after timeout", n, AW);
    chk("R4 in-band sample keeps det", det, 1);

    // R10: stalled tick freezes the sleep count
    tick = 1'b0;
    bad = 0;
    repeat (150) begin
      if (awake || fast) bad++;
      @(negedge clk);
    end
    chk("R10 no window without ticks", bad, 0);
    tick = 1'b1;
    count_sleep(n);
    chk("R10 full sleep after stall", n, SS);

    // drive into fast with det=1
    field = -12'sd50;
    count_awake(n);
    chk("R4 clear below release", det, 0);
    chk("R5 fast on clear", fast, 1);
    count_sleep(n);
    chk("R5 fast sleep length", n, FS);
    field = 12'sd50;
    count_awake(n);
    chk("R4 set above operate", det, 1);
    count_sleep(n);
    chk("R5 fast sleep again", n, FS);

    // R9: drop enable inside the window with a clearing field
    field = -12'sd100;
    en = 1'b0;
    @(negedge clk);
    chk("R9 awake off after disable", awake, 0);
    chk("R9 fast off after disable", fast, 0);
    bad = 0;
    repeat (20) begin
      if (det != 1'b1 || awake) bad++;
      @(negedge clk);
    end
    chk("R9 det held while disabled", bad, 0);
    field = '0;
    en = 1'b1;
    count_sleep(n);
    chk("R2 re-entry sleep length", n, SS);
    chk("R2 re-entry slow", fast, 0);
    count_awake(n);
    chk("R9 det kept across disable", det, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule